// File: doc/BRIEF.md
# Peak Polarity Pulse Qualifier

This block is the digital decision stage behind a disk read-channel pulse detector. Every peak event reaches it as a single-cycle zero-crossing strobe. Two flags come with the strobe: the sign of the peak, and whether the peak cleared its amplitude threshold. From these the block decides whether the peak counts as a data bit. Each accepted peak becomes one active-low read-data pulse of fixed width.

A select input chooses between two qualification rules. With split checking, positive and negative peaks are judged on their own threshold flags. With alternating checking, a peak is also required to have the opposite sign to the last accepted peak. Under that rule, one weak pulse costs two bits. The output drives only while the channel is in idle or servo operation. In every other mode it stays high, but qualification and polarity tracking still run.

Top module: `peak_qualifier`

## Requirements
- R1: After reset `rd_pulse_n` is high and no polarity is stored, so the first above-threshold peak of either sign is accepted in alternating mode.
- R2: With `split_chk` = 1, every strobe whose `over_thr` is 1 is accepted, whatever its sign and whatever the sign of earlier peaks.
- R3: With `split_chk` = 0, a strobe with `over_thr` = 1 is accepted only when no polarity is stored or its sign (`peak_pos` = 1 positive, 0 negative) differs from the stored one.
- R4: In alternating mode, the sequence accepted positive, sub-threshold negative, positive, negative gives pulses for the first and last peaks only: two missing bits.
- R5: A strobe with `over_thr` = 0 gives no pulse and leaves the stored polarity unchanged.
- R6: `over_thr` without `zc_strobe` gives no pulse.
- R7: Each accepted peak drives `rd_pulse_n` low for exactly PULSE_CYC = ceil(PULSE_PS / CLK_PERIOD_PS) cycles. The pulse begins in the cycle after the clock edge that samples the strobe.
- R8: `rd_pulse_n` may go low only while `op_mode` is idle (1) or servo (4). In sleep (0), read (2) and write (3) it stays high from the cycle after the mode is applied.
- R9: Qualification and the stored polarity keep updating while the output is disabled by `op_mode`.
- R10: A peak accepted while a pulse is running restarts the width count, so the low time runs PULSE_CYC cycles past the later peak.
- R11: Accepted peaks update the stored polarity in both modes, and `split_chk` is taken per strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| zc_strobe | input | 1 | One-cycle zero-crossing (peak position) strobe |
| peak_pos | input | 1 | Sign of the peak: 1 positive, 0 negative |
| over_thr | input | 1 | Peak amplitude exceeded its threshold |
| split_chk | input | 1 | 1: independent sign checking; 0: alternating rule |
| op_mode | input | 3 | Operating mode: 0 sleep, 1 idle, 2 read, 3 write, 4 servo |
| rd_pulse_n | output | 1 | Active-low qualified read-data pulse |

## Verification
The bench uses the default parameters: a 10 000 ps clock and a 24 000 ps target width. These give PULSE_CYC = 3. Because 24 ns is not a whole number of clock periods, the round-up path in the width calculation is exercised. A three-cycle pulse also keeps windows short enough that a second peak can land inside a running pulse. That brings the restart and the two-missing-bit sequences within a few cycles of each other.

// File: rtl/pkq_pkg.sv
`timescale 1ns/1ps
// Shared types for the peak qualifier.
// Assumes: one peak event per strobe, polarity carried as a single bit.
package pkq_pkg;

    // Stored sign of the last accepted peak
    typedef enum logic [1:0] {
        POL_NONE = 2'd0,
        POL_POS  = 2'd1,
        POL_NEG  = 2'd2
    } pol_e;

    // Channel operating modes
    typedef enum logic [2:0] {
        OPM_SLEEP = 3'd0,
        OPM_IDLE  = 3'd1,
        OPM_READ  = 3'd2,
        OPM_WRITE = 3'd3,
        OPM_SERVO = 3'd4
    } opm_e;

    // Integer division rounded up, at least one
    function automatic int ceil_cycles(input int span_ps, input int period_ps);
        int q;
        q = (span_ps + period_ps - 1) / period_ps;
        return (q < 1) ? 1 : q;
    endfunction

endpackage

// File: rtl/pkq_qualifier.sv
`timescale 1ns/1ps
// Decides whether a peak event is a data bit and tracks the sign of the
// last accepted peak. Assumes strobe and flags are synchronous to clk.
module pkq_qualifier
    import pkq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic zc_strobe,
    input  logic peak_pos,
    input  logic over_thr,
    input  logic split_chk,
    output logic qual
);

    pol_e last_q;
    pol_e pol_now;
    logic alt_ok;

    // Classify the incoming peak and apply the selected rule
    always_comb begin
        pol_now = peak_pos ? POL_POS : POL_NEG;
        alt_ok  = (last_q == POL_NONE) || (last_q != pol_now);
        qual    = zc_strobe && over_thr && (split_chk || alt_ok);
    end

    // Remember the sign of each accepted peak
    always_ff @(posedge clk) begin
        if (!rst_n)
            last_q <= POL_NONE;
        else if (qual)
            last_q <= pol_now;
    end

    assert_hold_under_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (zc_strobe && !over_thr) |=> $stable(last_q));

    assert_track_sign_R11: assert property (@(posedge clk) disable iff (!rst_n)
        qual |=> (last_q == ($past(peak_pos) ? POL_POS : POL_NEG)));

endmodule

// File: rtl/pkq_stretch.sv
`timescale 1ns/1ps
// Turns a single-cycle accept into a pulse of PULSE_CYC cycles; a new
// accept restarts the count. Assumes PULSE_CYC >= 1.
module pkq_stretch #(
    parameter int PULSE_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic qual_in,
    output logic active
);

    localparam int CW = $clog2(PULSE_CYC + 1);

    logic [CW-1:0] cnt;

    // Load on accept, otherwise count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (qual_in)
            cnt <= CW'(PULSE_CYC);
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    // Pulse is running while the count is nonzero
    assign active = (cnt != '0);

    assert_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
        qual_in |=> (cnt == CW'(PULSE_CYC)));

    assert_idle_stays_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!qual_in && cnt == '0) |=> !active);

endmodule

// File: rtl/pkq_outgate.sv
`timescale 1ns/1ps
// Registers the mode-based output enable and forms the active-low pin.
// Assumes op_mode is steady for at least one cycle before it matters.
module pkq_outgate
    import pkq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] op_mode,
    input  logic       active,
    output logic       rd_pulse_n
);

    logic en_q;
    logic en_d;

    // Output drives only in idle and servo modes
    always_comb begin
        en_d = (opm_e'(op_mode) == OPM_IDLE) || (opm_e'(op_mode) == OPM_SERVO);
    end

    // Hold the enable for one cycle
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= 1'b0;
        else
            en_q <= en_d;
    end

    // Low only while pulsing and enabled
    assign rd_pulse_n = !(active && en_q);

    assert_quiet_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !((op_mode == 3'd1) || (op_mode == 3'd4)) |=> rd_pulse_n);

endmodule

// File: rtl/peak_qualifier.sv
`timescale 1ns/1ps
// Top of the peak polarity pulse qualifier: rule selection, pulse
// stretching and mode gating. Assumes inputs synchronous to clk.
module peak_qualifier
    import pkq_pkg::*;
#(
    parameter int CLK_PERIOD_PS = 10000,
    parameter int PULSE_PS      = 24000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       zc_strobe,
    input  logic       peak_pos,
    input  logic       over_thr,
    input  logic       split_chk,
    input  logic [2:0] op_mode,
    output logic       rd_pulse_n
);

    localparam int PULSE_CYC = ceil_cycles(PULSE_PS, CLK_PERIOD_PS);

    logic qual;
    logic active;

    pkq_qualifier u_qual (
        .clk       (clk),
        .rst_n     (rst_n),
        .zc_strobe (zc_strobe),
        .peak_pos  (peak_pos),
        .over_thr  (over_thr),
        .split_chk (split_chk),
        .qual      (qual)
    );

    pkq_stretch #(.PULSE_CYC(PULSE_CYC)) u_stretch (
        .clk     (clk),
        .rst_n   (rst_n),
        .qual_in (qual),
        .active  (active)
    );

    pkq_outgate u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_mode    (op_mode),
        .active     (active),
        .rd_pulse_n (rd_pulse_n)
    );

    assert_no_pulse_without_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!zc_strobe && rd_pulse_n) |=> rd_pulse_n);

endmodule

// File: tb/sim_peak_qualifier.sv
`timescale 1ns/1ps
module sim_peak_qualifier;

    localparam int PC = (24000 + 10000 - 1) / 10000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       zc_strobe = 1'b0;
    logic       peak_pos = 1'b0;
    logic       over_thr = 1'b0;
    logic       split_chk = 1'b0;
    logic [2:0] op_mode = 3'd1;
    logic       rd_pulse_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    peak_qualifier u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .zc_strobe  (zc_strobe),
        .peak_pos   (peak_pos),
        .over_thr   (over_thr),
        .split_chk  (split_chk),
        .op_mode    (op_mode),
        .rd_pulse_n (rd_pulse_n)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        zc_strobe = 1'b0;
        over_thr = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic set_mode(input logic [2:0] m);
        @(negedge clk);
        op_mode = m;
        @(negedge clk);
    endtask

    // One peak event; checks first-cycle level (R7) and total low time
    task automatic peak(input bit pos, input bit over, input bit expq, input string req);
        int lows;
        bit first;
        lows = 0;
        @(negedge clk);
        zc_strobe = 1'b1;
        peak_pos = pos;
        over_thr = over;
        @(negedge clk);
        zc_strobe = 1'b0;
        over_thr = 1'b0;
        first = rd_pulse_n;
        for (int i = 0; i < PC + 2; i++) begin
            if (!rd_pulse_n) lows++;
            @(negedge clk);
        end
        check(lows == (expq ? PC : 0), req, lows, expq ? PC : 0);
        check(first == !expq, {req, "/R7 start"}, int'(first), int'(!expq));
    endtask

    task automatic t_reset();
        do_reset();
        check(rd_pulse_n == 1'b1, "R1 idle level", int'(rd_pulse_n), 1);
        split_chk = 1'b0;
        peak(1'b0, 1'b1, 1'b1, "R1 first negative");
        do_reset();
        peak(1'b1, 1'b1, 1'b1, "R1 first positive");
    endtask

    task automatic t_split();
        do_reset();
        split_chk = 1'b1;
        peak(1'b1, 1'b1, 1'b1, "R2 pos");
        peak(1'b1, 1'b1, 1'b1, "R2 pos again");
        peak(1'b0, 1'b1, 1'b1, "R2 neg");
        peak(1'b0, 1'b1, 1'b1, "R2 neg again");
    endtask

    task automatic t_alt();
        do_reset();
        split_chk = 1'b0;
        peak(1'b1, 1'b1, 1'b1, "R3 pos");
        peak(1'b1, 1'b1, 1'b0, "R3 repeat pos");
        peak(1'b0, 1'b1, 1'b1, "R3 neg");
        peak(1'b0, 1'b1, 1'b0, "R3 repeat neg");
        peak(1'b1, 1'b1, 1'b1, "R3 pos after neg");
    endtask

    task automatic t_two_missing();
        do_reset();
        split_chk = 1'b0;
        peak(1'b1, 1'b1, 1'b1, "R4 pos");
        peak(1'b0, 1'b0, 1'b0, "R4 weak neg");
        peak(1'b1, 1'b1, 1'b0, "R4 pos dropped");
        peak(1'b0, 1'b1, 1'b1, "R4 neg");
    endtask

    task automatic t_under();
        do_reset();
        split_chk = 1'b0;
        peak(1'b1, 1'b1, 1'b1, "R5 pos");
        peak(1'b1, 1'b0, 1'b0, "R5 weak pos");
        peak(1'b0, 1'b1, 1'b1, "R5 neg still opposite");
        split_chk = 1'b1;
        peak(1'b0, 1'b0, 1'b0, "R5 weak in split");
    endtask

    task automatic t_no_strobe();
        int lows;
        lows = 0;
        do_reset();
        split_chk = 1'b1;
        @(negedge clk);
        over_thr = 1'b1;
        for (int i = 0; i < PC + 3; i++) begin
            @(negedge clk);
            if (!rd_pulse_n) lows++;
        end
        over_thr = 1'b0;
        check(lows == 0, "R6 flag alone", lows, 0);
    endtask

    task automatic t_modes();
        do_reset();
        split_chk = 1'b1;
        set_mode(3'd0);
        peak(1'b1, 1'b1, 1'b0, "R8 sleep");
        set_mode(3'd2);
        peak(1'b0, 1'b1, 1'b0, "R8 read");
        set_mode(3'd3);
        peak(1'b1, 1'b1, 1'b0, "R8 write");
        set_mode(3'd4);
        peak(1'b0, 1'b1, 1'b1, "R8 servo");
        set_mode(3'd1);
        peak(1'b1, 1'b1, 1'b1, "R8 idle");
    endtask

    task automatic t_hidden();
        do_reset();
        split_chk = 1'b0;
        set_mode(3'd2);
        peak(1'b1, 1'b1, 1'b0, "R9 pos while read");
        set_mode(3'd1);
        peak(1'b1, 1'b1, 1'b0, "R9 pos rejected after hidden accept");
        peak(1'b0, 1'b1, 1'b1, "R9 neg");
    endtask

    task automatic t_restart();
        int lows;
        lows = 0;
        do_reset();
        split_chk = 1'b1;
        @(negedge clk);
        zc_strobe = 1'b1; peak_pos = 1'b1; over_thr = 1'b1;
        @(negedge clk);
        zc_strobe = 1'b0; over_thr = 1'b0;
        if (!rd_pulse_n) lows++;
        @(negedge clk);
        if (!rd_pulse_n) lows++;
        zc_strobe = 1'b1; peak_pos = 1'b0; over_thr = 1'b1;
        @(negedge clk);
        zc_strobe = 1'b0; over_thr = 1'b0;
        for (int i = 0; i < PC + 3; i++) begin
            if (!rd_pulse_n) lows++;
            @(negedge clk);
        end
        check(lows == PC + 2, "R10 restarted width", lows, PC + 2);
    endtask

    task automatic t_switch();
        do_reset();
        split_chk = 1'b1;
        peak(1'b1, 1'b1, 1'b1, "R11 pos split");
        peak(1'b1, 1'b1, 1'b1, "R11 pos split again");
        split_chk = 1'b0;
        peak(1'b1, 1'b1, 1'b0, "R11 pos after switch");
        peak(1'b0, 1'b1, 1'b1, "R11 neg after switch");
    endtask

    initial begin
        do_reset();
        t_reset();
        t_split();
        t_alt();
        t_two_missing();
        t_under();
        t_no_strobe();
        t_modes();
        t_hidden();
        t_restart();
        t_switch();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule